// File: doc/BRIEF.md
# Bus Cycle Style Converter

This block converts processor bus cycles that are framed by a valid-address flag plus a single read/write direction bit into peripheral cycles framed by separate active-low read and write strobes. It sits between a processor-side port, which is sampled on a fast system clock together with the processor's second clock phase, and a peripheral port that expects one strobe per direction. The enable, strobes, latched address and write data are all driven from a registered state machine, so they change only on system clock edges.

Two framing modes are selected by an input. In valid-flag mode a cycle exists only while the second phase and the valid flag are both high. In every-cycle mode the valid flag is ignored and each second phase is an access. The direction level that means "write" is a parameter. A write pulse is raised at the start of every write for a set number of clocks. It is cut short if the phase ends early. A change of direction in the middle of a phase forces one idle clock between the two strobes.

States: `ST_IDLE` (no strobe), `ST_READ` (read strobe low), `ST_WPULSE` (write strobe low, write pulse high, counting down), `ST_WHOLD` (write strobe low, pulse over). Transitions: `ST_IDLE`→`ST_READ` on a qualified read; `ST_IDLE`→`ST_WPULSE` on a qualified write; `ST_WPULSE`→`ST_WHOLD` when the pulse count is spent; `ST_READ`, `ST_WPULSE` and `ST_WHOLD`→`ST_IDLE` when the qualifier is lost or the direction differs from the current state.

Top module: `bus_cycle_bridge`

## Requirements
- R1: During and directly after reset, per_en is 0, per_rd_n and per_wr_n are 1, and per_wpulse is 0.
- R2: With mode_every = 0, per_en is 1 in the clock after an edge where ph2 = 1 and vma = 1, and is never 1 after an edge where vma = 0.
- R3: With mode_every = 1, vma has no effect: per_en is 1 in the clock after any edge where ph2 = 1.
- R4: A qualified cycle with rw different from WRITE_LEVEL drives per_rd_n low. per_rd_n and per_wr_n are never low in the same clock.
- R5: A qualified cycle with rw equal to WRITE_LEVEL drives per_wr_n low. WRITE_LEVEL is a parameter.
- R6: per_wpulse is 1 only while per_wr_n is low. It is high for the first PULSE_LEN clocks of a write, or fewer if the write ends sooner, and is never high in a read.
- R7: All strobes and per_en return to inactive in the clock after an edge where ph2 = 0, or where the valid flag is lost in valid-flag mode.
- R8: If rw changes while ph2 stays high, the running strobe ends and the opposite strobe starts one clock later, so exactly one idle clock separates them.
- R9: per_addr and per_wdata take cpu_addr and cpu_wdata at the edge that starts a cycle, and hold them for the whole strobe even if the processor inputs change.
- R10: cpu_rdata takes per_rdata at every edge while the read strobe is low, and keeps the last value after the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_every | input | 1 | 1 = every ph2 is an access, 0 = vma qualifies |
| ph2 | input | 1 | Processor second clock phase, sampled |
| vma | input | 1 | Valid-address flag |
| rw | input | 1 | Direction bit; equals WRITE_LEVEL for a write |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Read data returned to the processor |
| per_en | output | 1 | Generic access enable |
| per_rd_n | output | 1 | Active-low read strobe |
| per_wr_n | output | 1 | Active-low write strobe |
| per_wpulse | output | 1 | Write-only pulse at the start of a write |
| per_addr | output | AW | Held peripheral address |
| per_wdata | output | DW | Held peripheral write data |
| per_rdata | input | DW | Peripheral read data |

## Verification
The bench builds the block with WRITE_LEVEL = 0, which is the opposite of the default, so a design that ignores the polarity parameter swaps its strobes and is reported. PULSE_LEN = 3 makes the pulse long enough to tell apart a full pulse, a pulse cut short by a two-clock phase, and the hold state that follows it. A 12-bit address and 8-bit data make the latched-address and captured-read checks use values that differ in every nibble.

// File: rtl/bcb_pkg.sv
package bcb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WPULSE = 2'd2,
        ST_WHOLD  = 2'd3
    } bcb_state_e;

    localparam logic MODE_FLAG  = 1'b0;
    localparam logic MODE_EVERY = 1'b1;

endpackage

// File: rtl/bcb_qualify.sv
module bcb_qualify #(
    parameter logic WRITE_LEVEL = 1'b1
) (
    input  logic mode_every,
    input  logic ph2,
    input  logic vma,
    input  logic rw,
    output logic qual,
    output logic wr_req
);
    import bcb_pkg::*;

    logic flag_ok;

    always_comb begin
        flag_ok = (mode_every == MODE_EVERY) ? 1'b1 : vma;
        qual    = ph2 & flag_ok;
        wr_req  = (rw == WRITE_LEVEL);
    end

endmodule

// File: rtl/bcb_fsm.sv
module bcb_fsm #(
    parameter int PULSE_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    input  logic wr_req,
    output logic launch,
    output logic rd_active,
    output logic en,
    output logic rd_n,
    output logic wr_n,
    output logic wpulse
);
    import bcb_pkg::*;

    localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN + 1) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_LEN - 1);

    bcb_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (qual) begin
                    if (wr_req) begin
                        state_d = ST_WPULSE;
                        cnt_d   = CNT_LOAD;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (!qual || wr_req) state_d = ST_IDLE;
            end
            ST_WPULSE: begin
                if (!qual || !wr_req) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = ST_WHOLD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WHOLD: begin
                if (!qual || !wr_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        launch    = (state_q == ST_IDLE) && qual;
        rd_active = (state_q == ST_READ);
        en        = 1'b0;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        wpulse    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin
                en   = 1'b1;
                rd_n = 1'b0;
            end
            ST_WPULSE: begin
                en     = 1'b1;
                wr_n   = 1'b0;
                wpulse = 1'b1;
            end
            ST_WHOLD: begin
                en   = 1'b1;
                wr_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bcb_hold.sv
module bcb_hold #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          rd_active,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic [DW-1:0] per_rdata,
    output logic [AW-1:0] per_addr,
    output logic [DW-1:0] per_wdata,
    output logic [DW-1:0] cpu_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_addr  <= '0;
            per_wdata <= '0;
        end else if (launch) begin
            per_addr  <= cpu_addr;
            per_wdata <= cpu_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (rd_active) begin
            cpu_rdata <= per_rdata;
        end
    end

endmodule

// File: rtl/bus_cycle_bridge.sv
module bus_cycle_bridge #(
    parameter int   AW          = 16,
    parameter int   DW          = 8,
    parameter logic WRITE_LEVEL = 1'b1,
    parameter int   PULSE_LEN   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_every,
    input  logic          ph2,
    input  logic          vma,
    input  logic          rw,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          per_en,
    output logic          per_rd_n,
    output logic          per_wr_n,
    output logic          per_wpulse,
    output logic [AW-1:0] per_addr,
    output logic [DW-1:0] per_wdata,
    input  logic [DW-1:0] per_rdata
);

    logic qual;
    logic wr_req;
    logic launch;
    logic rd_active;

    bcb_qualify #(.WRITE_LEVEL(WRITE_LEVEL)) qual_i (
        .mode_every (mode_every),
        .ph2        (ph2),
        .vma        (vma),
        .rw         (rw),
        .qual       (qual),
        .wr_req     (wr_req)
    );

    bcb_fsm #(.PULSE_LEN(PULSE_LEN)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .qual      (qual),
        .wr_req    (wr_req),
        .launch    (launch),
        .rd_active (rd_active),
        .en        (per_en),
        .rd_n      (per_rd_n),
        .wr_n      (per_wr_n),
        .wpulse    (per_wpulse)
    );

    bcb_hold #(.AW(AW), .DW(DW)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .rd_active (rd_active),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .per_rdata (per_rdata),
        .per_addr  (per_addr),
        .per_wdata (per_wdata),
        .cpu_rdata (cpu_rdata)
    );

endmodule

// File: rtl/bus_cycle_bridge_chk.sv
module bus_cycle_bridge_chk #(
    parameter int   AW          = 16,
    parameter logic WRITE_LEVEL = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_every,
    input logic          ph2,
    input logic          vma,
    input logic          rw,
    input logic          per_en,
    input logic          per_rd_n,
    input logic          per_wr_n,
    input logic          per_wpulse,
    input logic [AW-1:0] per_addr
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!per_rd_n && !per_wr_n)); // R4

    AST_EN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        per_en |-> $past(ph2 && (mode_every || vma))); // R2

    AST_RD_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !per_rd_n |-> $past(rw != WRITE_LEVEL)); // R4

    AST_WR_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !per_wr_n |-> $past(rw == WRITE_LEVEL)); // R5

    AST_PULSE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        per_wpulse |-> !per_wr_n); // R6

    AST_END_ON_PH2_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ph2 |=> !per_en); // R7

    AST_RD_TO_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !per_rd_n |=> per_wr_n); // R8

    AST_WR_TO_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !per_wr_n |=> per_rd_n); // R8

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (per_en && $past(per_en)) |-> $stable(per_addr)); // R9

endmodule

bind bus_cycle_bridge bus_cycle_bridge_chk #(
    .AW          (AW),
    .WRITE_LEVEL (WRITE_LEVEL)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_every (mode_every),
    .ph2        (ph2),
    .vma        (vma),
    .rw         (rw),
    .per_en     (per_en),
    .per_rd_n   (per_rd_n),
    .per_wr_n   (per_wr_n),
    .per_wpulse (per_wpulse),
    .per_addr   (per_addr)
);

// File: tb/bus_cycle_bridge_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_bridge_tb_top;

    localparam int   AW  = 12;
    localparam int   DW  = 8;
    localparam logic WL  = 1'b0;
    localparam logic RDL = 1'b1;
    localparam int   PL  = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_every;
    logic          ph2;
    logic          vma;
    logic          rw;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic [DW-1:0] cpu_rdata;
    logic          per_en;
    logic          per_rd_n;
    logic          per_wr_n;
    logic          per_wpulse;
    logic [AW-1:0] per_addr;
    logic [DW-1:0] per_wdata;
    logic [DW-1:0] per_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bus_cycle_bridge #(
        .AW(AW), .DW(DW), .WRITE_LEVEL(WL), .PULSE_LEN(PL)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_every (mode_every),
        .ph2        (ph2),
        .vma        (vma),
        .rw         (rw),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .per_en     (per_en),
        .per_rd_n   (per_rd_n),
        .per_wr_n   (per_wr_n),
        .per_wpulse (per_wpulse),
        .per_addr   (per_addr),
        .per_wdata  (per_wdata),
        .per_rdata  (per_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // strobes as a 4-bit word {en, rd_n, wr_n, wpulse}
    function automatic logic [3:0] strb();
        return {per_en, per_rd_n, per_wr_n, per_wpulse};
    endfunction

    localparam logic [3:0] S_IDLE  = 4'b0110;
    localparam logic [3:0] S_READ  = 4'b1010;
    localparam logic [3:0] S_WPUL  = 4'b1101;
    localparam logic [3:0] S_WHOLD = 4'b1100;

    task automatic cyc(input logic p, input logic v, input logic r,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ph2 = p; vma = v; rw = r; cpu_addr = a; cpu_wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; mode_every = 1'b0; ph2 = 1'b0; vma = 1'b0;
        rw = RDL; cpu_addr = '0; cpu_wdata = '0; per_rdata = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", strb(), S_IDLE);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after reset", strb(), S_IDLE);
    endtask

    task automatic t_flag_read();
        mode_every = 1'b0;
        per_rdata = 8'hA5;
        cyc(1, 1, RDL, 12'h123, 8'h00);
        check("R2/R4 read strobe", strb(), S_READ);
        check("R9 addr latched", per_addr, 12'h123);
        cyc(1, 1, RDL, 12'h456, 8'h00);
        check("R9 addr held", per_addr, 12'h123);
        check("R6 no pulse in read", per_wpulse, 1'b0);
        cyc(0, 1, RDL, 12'h456, 8'h00);
        check("R7 end on ph2 low", strb(), S_IDLE);
        check("R10 read data", cpu_rdata, 8'hA5);
        per_rdata = 8'h3C;
        cyc(0, 0, RDL, 12'h000, 8'h00);
        check("R10 read data kept", cpu_rdata, 8'hA5);
    endtask

    task automatic t_flag_low();
        mode_every = 1'b0;
        for (int i = 0; i < 3; i++) begin
            cyc(1, 0, RDL, 12'h0AA, 8'h00);
            check("R2 no read without vma", strb(), S_IDLE);
        end
        cyc(1, 0, WL, 12'h0AA, 8'h11);
        check("R2 no write without vma", strb(), S_IDLE);
        cyc(0, 0, RDL, 12'h000, 8'h00);
    endtask

    task automatic t_every();
        mode_every = 1'b1;
        cyc(1, 0, RDL, 12'h7E1, 8'h00);
        check("R3 every-cycle read", strb(), S_READ);
        check("R3 addr", per_addr, 12'h7E1);
        cyc(0, 0, RDL, 12'h7E1, 8'h00);
        check("R3/R7 end", strb(), S_IDLE);
        cyc(1, 0, WL, 12'h7E2, 8'h99);
        check("R3 every-cycle write", strb(), S_WPUL);
        cyc(0, 0, WL, 12'h7E2, 8'h99);
        mode_every = 1'b0;
    endtask

    task automatic t_write_full();
        mode_every = 1'b0;
        cyc(1, 1, WL, 12'h2F0, 8'h3C);
        check("R5/R6 write pulse c1", strb(), S_WPUL);
        check("R9 write addr", per_addr, 12'h2F0);
        check("R9 write data", per_wdata, 8'h3C);
        cyc(1, 1, WL, 12'h111, 8'hC3);
        check("R6 write pulse c2", strb(), S_WPUL);
        check("R9 write data held", per_wdata, 8'h3C);
        cyc(1, 1, WL, 12'h111, 8'hC3);
        check("R6 write pulse c3", strb(), S_WPUL);
        cyc(1, 1, WL, 12'h111, 8'hC3);
        check("R6 pulse over c4", strb(), S_WHOLD);
        cyc(1, 1, WL, 12'h111, 8'hC3);
        check("R5 write held c5", strb(), S_WHOLD);
        cyc(0, 1, WL, 12'h111, 8'hC3);
        check("R7 write ends", strb(), S_IDLE);
    endtask

    task automatic t_write_short();
        cyc(1, 1, WL, 12'h040, 8'h01);
        check("R6 short pulse c1", strb(), S_WPUL);
        cyc(1, 1, WL, 12'h040, 8'h01);
        check("R6 short pulse c2", strb(), S_WPUL);
        cyc(0, 1, WL, 12'h040, 8'h01);
        check("R6 short pulse cut", strb(), S_IDLE);
    endtask

    task automatic t_flip();
        cyc(1, 1, RDL, 12'h500, 8'h00);
        check("R8 read first", strb(), S_READ);
        cyc(1, 1, WL, 12'h501, 8'h77);
        check("R8 idle gap", strb(), S_IDLE);
        cyc(1, 1, WL, 12'h501, 8'h77);
        check("R8 write after gap", strb(), S_WPUL);
        check("R9 new addr", per_addr, 12'h501);
        cyc(1, 1, RDL, 12'h502, 8'h00);
        check("R8 gap after write", strb(), S_IDLE);
        cyc(1, 1, RDL, 12'h502, 8'h00);
        check("R8 read after gap", strb(), S_READ);
        cyc(0, 0, RDL, 12'h000, 8'h00);
    endtask

    task automatic t_flag_drop();
        cyc(1, 1, RDL, 12'h620, 8'h00);
        check("R2 read started", strb(), S_READ);
        cyc(1, 0, RDL, 12'h620, 8'h00);
        check("R7 vma lost ends read", strb(), S_IDLE);
        cyc(0, 0, RDL, 12'h000, 8'h00);
    endtask

    initial begin
        t_reset();
        t_flag_read();
        t_flag_low();
        t_every();
        t_write_full();
        t_write_short();
        t_flip();
        t_flag_drop();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule